// File: doc/BRIEF.md
# Linked Instruction/Data Breakpoint Qualifier

This block decides, for each retiring instruction, which debug compare events are reported. It sits behind four data-address comparators and four instruction-address comparators (the odd-numbered ones: first, third, fifth and seventh). Their hit flags arrive as inputs along with the tag of the instruction that caused each hit. The address compare itself, and any interrupt or halt response, happen elsewhere.

Each data comparator has a fixed partner among the instruction comparators. When a pair is linked, its data event fires only if the same instruction also hits the partner instruction comparator. The instruction comparator of a linked pair never reports anything of its own. Linking works only in external or internal debug mode. The second and fourth data comparators cannot be linked while they serve as a mask or range bound for their neighbour. Events leave as one-cycle pulses. They also set sticky bits in a status register, and software clears those bits by writing 1.

Top module: `linked_bkpt_qual`

## Requirements
- R1: Pair index k (0..3) links data comparator k with instruction hit input k, which is instruction comparator 2k+1. A linked data event for pair k depends only on instruction hit k and not on any other instruction hit input.
- R2: A linked data event for pair k needs insn_valid_i, dac_hit_i[k], dac_en_i[k], iac_hit_i[k] and dac_tag_i == iac_tag_i, all in the same cycle. If the tags differ, there is no event.
- R3: When shared_i[0] is 1, the link bit of pair 1 is ignored. When shared_i[1] is 1, the link bit of pair 3 is ignored. Such a pair behaves as unlinked.
- R4: Link bits take effect only while ext_dbg_i or int_dbg_i is 1. Otherwise every pair behaves as unlinked.
- R5: For an effectively linked pair, iac_evt_o[k] and status bit 4+k are never set. This holds whatever the value of iac_en_i[k] and whether or not the data event occurs.
- R6: ldst_abort_i suppresses the data event of every effectively linked pair for that instruction. It has no effect on unlinked pairs.
- R7: For an unlinked pair, dac_evt_o[k] follows dac_hit_i[k] & dac_en_i[k] and iac_evt_o[k] follows iac_hit_i[k] & iac_en_i[k], each qualified by insn_valid_i.
- R8: Events are one-cycle pulses that appear on the clock edge that samples the instruction. sts_set_o equals {iac_evt_o, dac_evt_o}.
- R9: sts_o[3:0] holds the data status and sts_o[7:4] holds the instruction status. A bit stays 1 until sts_clr_i writes 1 to it. A set and a clear of the same bit in the same cycle leave the bit at 1.
- R10: After reset, all events, set pulses and status bits are 0.
- R11: With insn_valid_i at 0, no event is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | An instruction is presented this cycle |
| dac_tag_i | input | TAG_W | Tag of the instruction that made the data hits |
| iac_tag_i | input | TAG_W | Tag of the instruction that made the instruction hits |
| dac_hit_i | input | NUM_PAIRS | Data comparator hits |
| iac_hit_i | input | NUM_PAIRS | Instruction comparator hits for comparators 1,3,5,7 |
| dac_en_i | input | NUM_PAIRS | Per-comparator data event enables |
| iac_en_i | input | NUM_PAIRS | Per-comparator instruction event enables |
| link_en_i | input | NUM_PAIRS | Per-pair link request |
| ext_dbg_i | input | 1 | External debug mode active |
| int_dbg_i | input | 1 | Internal debug mode active |
| shared_i | input | NUM_PAIRS/2 | Data comparators 2 and 4 used as mask or range bound |
| ldst_abort_i | input | 1 | Load/store-multiple interrupted before completion |
| sts_clr_i | input | 2*NUM_PAIRS | Write-1-to-clear strobes for the status bits |
| dac_evt_o | output | NUM_PAIRS | Data event pulses |
| iac_evt_o | output | NUM_PAIRS | Instruction event pulses |
| sts_set_o | output | 2*NUM_PAIRS | Status set request pulses |
| sts_o | output | 2*NUM_PAIRS | Sticky status register |

## Verification
The assertions check the following on every cycle. A linked pair never emits an instruction event. A linked data event always follows a valid instruction with a partner hit and matching tags, and no abort. A mask-or-range comparator is never linked. Events never follow an idle cycle. A status bit rises only after a set request and falls only after a clear strobe. Other behaviours need directed scenarios from the bench: the pairing across all four pairs, the switch back to unlinked outside debug mode, enable gating on unlinked pairs, set winning over a clear, and the exact pulse timing.

// File: rtl/lbq_pkg.sv
package lbq_pkg;
  localparam int NUM_PAIRS_DEF = 4;
  localparam int TAG_W_DEF     = 6;

  typedef struct packed {
    logic valid;
    logic dac_hit;
    logic dac_en;
    logic iac_hit;
    logic iac_en;
    logic tag_match;
    logic abort;
  } pair_in_t;
endpackage

// File: rtl/lbq_link_ctrl.sv
module lbq_link_ctrl #(
  parameter int NUM_PAIRS = 4,
  localparam int NSH = NUM_PAIRS / 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PAIRS-1:0] link_en_i,
  input  logic                 ext_dbg_i,
  input  logic                 int_dbg_i,
  input  logic [NSH-1:0]       shared_i,
  output logic [NUM_PAIRS-1:0] link_act_o
);
  logic dbg_mode;
  assign dbg_mode = ext_dbg_i | int_dbg_i;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    if (k % 2 == 1) begin : g_shareable
      assign link_act_o[k] = link_en_i[k] & dbg_mode & ~shared_i[k/2];
      // R3
      shared_unlinked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shared_i[k/2] |-> !link_act_o[k]);
    end else begin : g_plain
      assign link_act_o[k] = link_en_i[k] & dbg_mode;
    end
  end

  // R4
  nodbg_unlinked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_dbg_i || int_dbg_i) |-> (link_act_o == '0));
endmodule

// File: rtl/lbq_pair_qual.sv
module lbq_pair_qual
  import lbq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pair_in_t in_i,
  input  logic     link_act_i,
  output logic     dac_evt_o,
  output logic     iac_evt_o
);
  logic dac_base, linked_ok, dac_d, iac_d;

  assign dac_base  = in_i.valid & in_i.dac_hit & in_i.dac_en;
  // linked: same instruction must also hit the partner, and not be aborted
  assign linked_ok = in_i.iac_hit & in_i.tag_match & ~in_i.abort;
  assign dac_d     = dac_base & (~link_act_i | linked_ok);
  assign iac_d     = in_i.valid & in_i.iac_hit & in_i.iac_en & ~link_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_evt_o <= 1'b0;
      iac_evt_o <= 1'b0;
    end else begin
      dac_evt_o <= dac_d;
      iac_evt_o <= iac_d;
    end
  end

  // R5
  linked_iac_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iac_evt_o |-> !$past(link_act_i));
  // R2
  linked_dac_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_evt_o && $past(link_act_i)) |-> ($past(in_i.iac_hit) && $past(in_i.tag_match)));
  // R6
  linked_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_evt_o && $past(link_act_i)) |-> !$past(in_i.abort));
  // R11
  idle_no_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_evt_o || iac_evt_o) |-> $past(in_i.valid));
endmodule

// File: rtl/lbq_status.sv
module lbq_status #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_i) | set_i;  // set wins
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R9
    sts_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sts_o[i]) |-> $past(set_i[i]));
    // R9
    sts_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sts_o[i]) |-> $past(clr_i[i]));
  end
endmodule

// File: rtl/linked_bkpt_qual.sv
module linked_bkpt_qual
  import lbq_pkg::*;
#(
  parameter int NUM_PAIRS = NUM_PAIRS_DEF,
  parameter int TAG_W     = TAG_W_DEF,
  localparam int NSH = NUM_PAIRS / 2,
  localparam int SW  = 2 * NUM_PAIRS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 insn_valid_i,
  input  logic [TAG_W-1:0]     dac_tag_i,
  input  logic [TAG_W-1:0]     iac_tag_i,
  input  logic [NUM_PAIRS-1:0] dac_hit_i,
  input  logic [NUM_PAIRS-1:0] iac_hit_i,
  input  logic [NUM_PAIRS-1:0] dac_en_i,
  input  logic [NUM_PAIRS-1:0] iac_en_i,
  input  logic [NUM_PAIRS-1:0] link_en_i,
  input  logic                 ext_dbg_i,
  input  logic                 int_dbg_i,
  input  logic [NSH-1:0]       shared_i,
  input  logic                 ldst_abort_i,
  input  logic [SW-1:0]        sts_clr_i,
  output logic [NUM_PAIRS-1:0] dac_evt_o,
  output logic [NUM_PAIRS-1:0] iac_evt_o,
  output logic [SW-1:0]        sts_set_o,
  output logic [SW-1:0]        sts_o
);
  logic [NUM_PAIRS-1:0] link_act;
  logic                 tag_match;

  assign tag_match = (dac_tag_i == iac_tag_i);

  lbq_link_ctrl #(.NUM_PAIRS(NUM_PAIRS)) u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_en_i (link_en_i),
    .ext_dbg_i (ext_dbg_i),
    .int_dbg_i (int_dbg_i),
    .shared_i  (shared_i),
    .link_act_o(link_act)
  );

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    pair_in_t pin;
    assign pin = '{valid:     insn_valid_i,
                   dac_hit:   dac_hit_i[k],
                   dac_en:    dac_en_i[k],
                   iac_hit:   iac_hit_i[k],
                   iac_en:    iac_en_i[k],
                   tag_match: tag_match,
                   abort:     ldst_abort_i};
    lbq_pair_qual u_qual (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_i      (pin),
      .link_act_i(link_act[k]),
      .dac_evt_o (dac_evt_o[k]),
      .iac_evt_o (iac_evt_o[k])
    );
  end

  assign sts_set_o = {iac_evt_o, dac_evt_o};

  // set requests are registered pulses; status merges the same-cycle decision
  logic [SW-1:0] set_d;
  always_comb begin
    set_d = '0;
    for (int k = 0; k < NUM_PAIRS; k++) begin
      set_d[k]             = insn_valid_i & dac_hit_i[k] & dac_en_i[k] &
                             (~link_act[k] | (iac_hit_i[k] & tag_match & ~ldst_abort_i));
      set_d[NUM_PAIRS + k] = insn_valid_i & iac_hit_i[k] & iac_en_i[k] & ~link_act[k];
    end
  end

  lbq_status #(.W(SW)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_d),
    .clr_i (sts_clr_i),
    .sts_o (sts_o)
  );

  // R8
  set_matches_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_set_o & ~sts_o) == '0));
endmodule

// File: tb/linked_bkpt_qual_test.sv
`timescale 1ns/1ps
module linked_bkpt_qual_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid;
  logic [5:0] dtag, itag;
  logic [3:0] dhit, ihit, den, ien, lnk;
  logic       ext, intd, abort;
  logic [1:0] shr;
  logic [7:0] clr;
  logic [3:0] devt, ievt;
  logic [7:0] sset, sts;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  linked_bkpt_qual uut (
    .clk_i(clk), .rst_ni(rst_n), .insn_valid_i(valid),
    .dac_tag_i(dtag), .iac_tag_i(itag),
    .dac_hit_i(dhit), .iac_hit_i(ihit), .dac_en_i(den), .iac_en_i(ien),
    .link_en_i(lnk), .ext_dbg_i(ext), .int_dbg_i(intd), .shared_i(shr),
    .ldst_abort_i(abort), .sts_clr_i(clr),
    .dac_evt_o(devt), .iac_evt_o(ievt), .sts_set_o(sset), .sts_o(sts)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    valid = 0; dtag = 6'd5; itag = 6'd5; dhit = 0; ihit = 0;
    den = 4'hF; ien = 4'hF; lnk = 0; ext = 0; intd = 0; abort = 0;
    shr = 0; clr = 0;
  endtask

  // drive at negedge, the sampling posedge follows, check at next negedge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    idle_inputs(); clr = 8'hFF; step(); idle_inputs(); step();
  endtask

  task automatic t_reset();
    chk("R10 dac_evt", {4'h0, devt}, 8'h00);
    chk("R10 iac_evt", {4'h0, ievt}, 8'h00);
    chk("R10 sts", sts, 8'h00);
    chk("R10 set", sset, 8'h00);
  endtask

  task automatic t_unlinked();
    clear_all();
    valid = 1; dhit = 4'b0101; ihit = 4'b0011; step();
    chk("R7 dac_evt", {4'h0, devt}, 8'h05);
    chk("R7 iac_evt", {4'h0, ievt}, 8'h03);
    chk("R8 set", sset, 8'h35);
    chk("R9 sts set", sts, 8'h35);
    idle_inputs(); step();
    chk("R8 pulse ends", sset, 8'h00);
    chk("R9 sticky", sts, 8'h35);
    clear_all();
    valid = 1; dhit = 4'hF; ihit = 4'hF; den = 4'b0001; ien = 4'b1000; step();
    chk("R7 enable gating", {ievt, devt}, 8'h81);
  endtask

  task automatic t_w1c();
    clear_all();
    chk("R9 cleared", sts, 8'h00);
    valid = 1; dhit = 4'b0011; step();
    idle_inputs(); valid = 1; dhit = 4'b0001; clr = 8'h03; step();
    chk("R9 set wins over clear", sts, 8'h01);
  endtask

  task automatic t_linked();
    clear_all();
    valid = 1; lnk = 4'hF; ext = 1; dhit = 4'hF; ihit = 4'b0101; ien = 4'h0; step();
    chk("R1 R2 linked dac", {4'h0, devt}, 8'h05);
    chk("R5 linked iac silent", {4'h0, ievt}, 8'h00);
    chk("R5 status", sts, 8'h05);
    clear_all();
    valid = 1; lnk = 4'hF; ext = 1; dhit = 4'b0001; ihit = 4'b0010; step();
    chk("R1 wrong partner", {ievt, devt}, 8'h00);
    clear_all();
    valid = 1; lnk = 4'hF; ext = 1; dhit = 4'b0001; ihit = 4'b0001; itag = 6'd9; step();
    chk("R2 tag mismatch", {ievt, devt}, 8'h00);
    clear_all();
    valid = 1; lnk = 4'hF; intd = 1; ihit = 4'hF; step();
    chk("R5 iac-only linked", sts, 8'h00);
  endtask

  task automatic t_modes();
    clear_all();
    valid = 1; lnk = 4'hF; dhit = 4'b0001; ihit = 4'b0100; step();
    chk("R4 no debug mode unlinked", {ievt, devt}, 8'h41);
    clear_all();
    valid = 1; lnk = 4'hF; intd = 1; dhit = 4'b0001; ihit = 4'b0000; step();
    chk("R4 internal mode links", {ievt, devt}, 8'h00);
    clear_all();
    valid = 1; lnk = 4'hF; intd = 1; shr = 2'b11; dhit = 4'b1010; ihit = 4'b1010; itag = 6'd1; step();
    chk("R3 shared pairs unlinked", {ievt, devt}, 8'hAA);
    clear_all();
    valid = 1; lnk = 4'hF; ext = 1; shr = 2'b01; dhit = 4'b1010; step();
    chk("R3 only pair1 freed", {ievt, devt}, 8'h02);
  endtask

  task automatic t_abort();
    clear_all();
    valid = 1; lnk = 4'hF; ext = 1; dhit = 4'b0001; ihit = 4'b0001; abort = 1; step();
    chk("R6 linked abort", {ievt, devt}, 8'h00);
    clear_all();
    valid = 1; dhit = 4'b0001; abort = 1; step();
    chk("R6 unlinked unaffected", {ievt, devt}, 8'h01);
  endtask

  task automatic t_idle();
    clear_all();
    valid = 0; dhit = 4'hF; ihit = 4'hF; step();
    chk("R11 invalid", {ievt, devt}, 8'h00);
    chk("R11 sts", sts, 8'h00);
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_unlinked();
    t_w1c();
    t_linked();
    t_modes();
    t_abort();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule